// File: doc/BRIEF.md
# Ordered Store Buffer with Fence

This block sits between the memory port of a simple in-order core and a single-port shared memory. A store from the core goes into a small private queue and is acknowledged in the same cycle, so the core can continue at once. The queue writes its entries to memory in the background, oldest first, whenever the memory port is free. Any other agent that reads the memory therefore sees this core's stores in program order. None of them can see a store that is still queued.

A load from the core reads memory directly, and may pass older queued stores to other addresses. When the load address matches one or more queued entries, the newest matching entry supplies the data, so the core always sees its own writes. A fence request is held off until the queue is empty, and a busy flag is raised while it waits. A second read-only port lets an outside observer read memory. It has the highest priority on the shared memory port, so it shows exactly what has become visible so far.

Top module: `ordered_store_buffer`

## Requirements
- R1: A store (op code 1) offered while the queue holds fewer than DEPTH entries is accepted in the same cycle (`cpu_req_ready` high), and the core may offer its next request in the following cycle.
- R2: While DEPTH entries are queued and none has been written out, a store is refused (`cpu_req_ready` low). It is accepted in the cycle after one entry has been written to memory.
- R3: Queued entries reach memory strictly oldest first. An observer never sees a store while an earlier store from the same core is still missing, and two stores to one address leave the later value.
- R4: A queued store is invisible on the observer port. `obs_rd_data` returns the previous memory contents until that entry has been written.
- R5: A load (op code 0) whose address matches no queued entry returns the current memory word, even while older stores to other addresses are still queued.
- R6: A load whose address matches queued entries returns the data of the newest matching entry.
- R7: A fence (op code 2) is refused while any entry is queued. `busy` stays high while the fence waits, and both `busy` going low and the fence being accepted happen in the cycle after the last entry is written.
- R8: The memory is accessed at most once per cycle. An observer read wins over a core load miss, and a core load miss wins over a queue write. A load miss is refused while the observer reads, and a queue write waits for a free cycle.
- R9: Reset empties the queue and drops pending entries without writing them to memory.
- R10: An accepted load raises `cpu_rsp_valid` with its data in the following cycle. Observer data likewise appears in the cycle after `obs_rd_en`.

Code 3 on `cpu_req_op` is reserved: it is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Core request present |
| cpu_req_ready | output | 1 | Core request accepted this cycle |
| cpu_req_op | input | 2 | 0 load, 1 store, 2 fence, 3 reserved |
| cpu_req_addr | input | AW (8) | Word address of load or store |
| cpu_req_wdata | input | DW (16) | Store data |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_rdata | output | DW (16) | Load data |
| busy | output | 1 | Fence waiting for the queue to empty |
| obs_rd_en | input | 1 | Observer read request |
| obs_rd_addr | input | AW (8) | Observer word address |
| obs_rd_data | output | DW (16) | Observer read data, one cycle after the request |

## Verification
A read pointer that advances wrongly becomes visible on the observer port within one free memory cycle: a younger value shows up while an older one is still missing, or a stale word remains after a fence. A wrong fill count changes when the queue refuses stores or fences, and that shows as a ready or busy level off by a cycle or more. It also makes forwarding return data from slots that are already empty. The bench holds the observer port busy to keep entries queued for as long as it needs. This makes every ordering and visibility check land on a known cycle.

// File: rtl/osb_pkg.sv
package osb_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_NONE  = 2'd3
  } osb_op_e;

  // requester slots on the shared memory port, lowest index wins
  localparam int unsigned PORT_OBS   = 0;
  localparam int unsigned PORT_LOAD  = 1;
  localparam int unsigned PORT_DRAIN = 2;
  localparam int unsigned PORT_COUNT = 3;

endpackage

// File: rtl/osb_fifo.sv
module osb_fifo #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [AW-1:0]                push_addr_i,
  input  logic [DW-1:0]                push_data_i,
  input  logic                         pop_i,
  input  logic [AW-1:0]                lookup_addr_i,
  output logic                         full_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic [AW-1:0]                head_addr_o,
  output logic [DW-1:0]                head_data_o,
  output logic                         fwd_hit_o,
  output logic [DW-1:0]                fwd_data_o
);

  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, head_d;
  logic [PW-1:0] tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] slot_we;
  logic [PW-1:0] scan_idx;

  // per-slot write enables
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot_we
    assign slot_we[e] = push_i && (tail_q == PW'(e));
  end

  // next-state
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (push_i) tail_d = tail_q + PW'(1);
    if (pop_i)  head_d = head_q + PW'(1);
    cnt_d = cnt_q + CW'(push_i) - CW'(pop_i);
  end

  // pointer and count registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // entry storage, no reset on payload
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (slot_we[e]) begin
        addr_q[e] <= push_addr_i;
        data_q[e] <= push_data_i;
      end
    end
  end

  // walk from oldest to newest; a later match overrides an earlier one
  always_comb begin
    fwd_hit_o  = 1'b0;
    fwd_data_o = '0;
    scan_idx   = head_q;
    for (int k = 0; k < DEPTH; k++) begin
      scan_idx = head_q + PW'(k);
      if ((CW'(k) < cnt_q) && (addr_q[scan_idx] == lookup_addr_i)) begin
        fwd_hit_o  = 1'b1;
        fwd_data_o = data_q[scan_idx];
      end
    end
  end

  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign count_o     = cnt_q;
  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];

endmodule

// File: rtl/osb_arb.sv
module osb_arb #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);

  logic taken;

  always_comb begin
    gnt_o = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !taken) begin
        gnt_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/osb_ram.sv
module osb_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_q       <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/ordered_store_buffer.sv
module ordered_store_buffer #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic [1:0]    cpu_req_op,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_rsp_valid,
  output logic [DW-1:0] cpu_rsp_rdata,
  output logic          busy,
  input  logic          obs_rd_en,
  input  logic [AW-1:0] obs_rd_addr,
  output logic [DW-1:0] obs_rd_data
);

  import osb_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH+1);

  // request decode
  logic is_load, is_store, is_fence;
  assign is_load  = cpu_req_valid && (cpu_req_op == OP_LOAD);
  assign is_store = cpu_req_valid && (cpu_req_op == OP_STORE);
  assign is_fence = cpu_req_valid && (cpu_req_op == OP_FENCE);

  // queue
  logic          sb_full, sb_empty;
  logic [CW-1:0] sb_count;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic          fwd_hit;
  logic [DW-1:0] fwd_data;
  logic          push, pop;

  // memory port arbitration
  logic [PORT_COUNT-1:0] port_req, port_gnt;
  logic obs_gnt, load_gnt, drain_gnt;

  assign port_req[PORT_OBS]   = obs_rd_en;
  assign port_req[PORT_LOAD]  = is_load && !fwd_hit;
  assign port_req[PORT_DRAIN] = !sb_empty;
  assign obs_gnt   = port_gnt[PORT_OBS];
  assign load_gnt  = port_gnt[PORT_LOAD];
  assign drain_gnt = port_gnt[PORT_DRAIN];

  osb_arb #(.N(PORT_COUNT)) u_arb (
    .req_i (port_req),
    .gnt_o (port_gnt)
  );

  assign push = is_store && !sb_full;
  assign pop  = drain_gnt;

  osb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_i        (push),
    .push_addr_i   (cpu_req_addr),
    .push_data_i   (cpu_req_wdata),
    .pop_i         (pop),
    .lookup_addr_i (cpu_req_addr),
    .full_o        (sb_full),
    .empty_o       (sb_empty),
    .count_o       (sb_count),
    .head_addr_o   (head_addr),
    .head_data_o   (head_data),
    .fwd_hit_o     (fwd_hit),
    .fwd_data_o    (fwd_data)
  );

  // shared memory
  logic          ram_en;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_rdata;

  assign ram_en = obs_gnt || load_gnt || drain_gnt;

  always_comb begin
    ram_addr = head_addr;
    if (obs_gnt)       ram_addr = obs_rd_addr;
    else if (load_gnt) ram_addr = cpu_req_addr;
  end

  osb_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk     (clk),
    .en_i    (ram_en),
    .we_i    (drain_gnt),
    .addr_i  (ram_addr),
    .wdata_i (head_data),
    .rdata_o (ram_rdata)
  );

  // core handshake
  always_comb begin
    unique case (cpu_req_op)
      OP_LOAD:  cpu_req_ready = fwd_hit || load_gnt;
      OP_STORE: cpu_req_ready = !sb_full;
      OP_FENCE: cpu_req_ready = sb_empty;
      default:  cpu_req_ready = 1'b1;
    endcase
  end

  assign busy = is_fence && !sb_empty;

  // load response registers
  logic          load_fire;
  logic          rsp_valid_q, rsp_valid_d;
  logic          rsp_fwd_q, rsp_fwd_d;
  logic [DW-1:0] rsp_data_q;
  logic          rsp_data_en;

  assign load_fire   = is_load && cpu_req_ready;
  assign rsp_data_en = load_fire && fwd_hit;

  always_comb begin
    rsp_valid_d = load_fire;
    rsp_fwd_d   = rsp_fwd_q;
    if (load_fire) rsp_fwd_d = fwd_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_fwd_q   <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_fwd_q   <= rsp_fwd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_data_en) rsp_data_q <= fwd_data;
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_fwd_q ? rsp_data_q : ram_rdata;
  assign obs_rd_data   = ram_rdata;

endmodule

// File: rtl/osb_checker.sv
module osb_checker #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req_valid,
  input logic          cpu_req_ready,
  input logic [1:0]    cpu_req_op,
  input logic          cpu_rsp_valid,
  input logic          busy,
  input logic          obs_rd_en,
  input logic          obs_gnt,
  input logic          load_gnt,
  input logic          drain_gnt,
  input logic [CW-1:0] sb_count
);

  import osb_pkg::*;

  // R2: fill level never exceeds the queue depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sb_count <= CW'(DEPTH));

  // R1: an accepted store without a write-out grows the queue by one
  a_r1_store_enqueues: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && cpu_req_op == OP_STORE && !drain_gnt)
      |=> sb_count == $past(sb_count) + CW'(1));

  // R3: a write-out without a new store shrinks the queue by one
  a_r3_drain_dequeues: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_gnt && !(cpu_req_valid && cpu_req_ready && cpu_req_op == OP_STORE))
      |=> sb_count == $past(sb_count) - CW'(1));

  // R8: single memory access per cycle
  a_r8_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({obs_gnt, load_gnt, drain_gnt}));

  // R8 / R4: observer read blocks a write-out in the same cycle
  a_r8_obs_first: assert property (@(posedge clk) disable iff (!rst_n)
    obs_rd_en |-> !drain_gnt);

  // R7: a fence is never accepted while entries remain
  a_r7_fence_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_op == OP_FENCE && sb_count != '0)
      |-> (!cpu_req_ready && busy));

  // R10: accepted load answers in the next cycle
  a_r10_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && cpu_req_op == OP_LOAD) |=> cpu_rsp_valid);

  // R9: queue is empty right after reset release
  a_r9_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sb_count == '0));

endmodule

bind ordered_store_buffer osb_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/ordered_store_buffer_test.sv
module ordered_store_buffer_test;

  logic        clk;
  logic        rst_n;
  logic        cpu_req_valid;
  logic        cpu_req_ready;
  logic [1:0]  cpu_req_op;
  logic [7:0]  cpu_req_addr;
  logic [15:0] cpu_req_wdata;
  logic        cpu_rsp_valid;
  logic [15:0] cpu_rsp_rdata;
  logic        busy;
  logic        obs_rd_en;
  logic [7:0]  obs_rd_addr;
  logic [15:0] obs_rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  ordered_store_buffer uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_op(cpu_req_op), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .busy(busy),
    .obs_rd_en(obs_rd_en), .obs_rd_addr(obs_rd_addr), .obs_rd_data(obs_rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, FN = 2'd2;

  // {op, addr, wdata, expected load data}
  localparam logic [41:0] VEC [0:13] = '{
    {ST, 8'h10, 16'h1111, 16'h0000},
    {ST, 8'h11, 16'h2222, 16'h0000},
    {ST, 8'h12, 16'h3333, 16'h0000},
    {ST, 8'h13, 16'h4444, 16'h0000},
    {LD, 8'h11, 16'h0000, 16'h2222},
    {ST, 8'h11, 16'h5555, 16'h0000},
    {LD, 8'h11, 16'h0000, 16'h5555},
    {FN, 8'h00, 16'h0000, 16'h0000},
    {LD, 8'h10, 16'h0000, 16'h1111},
    {LD, 8'h13, 16'h0000, 16'h4444},
    {ST, 8'h14, 16'h6666, 16'h0000},
    {ST, 8'h15, 16'h7777, 16'h0000},
    {FN, 8'h00, 16'h0000, 16'h0000},
    {LD, 8'h15, 16'h0000, 16'h7777}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic core_op(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                         output logic [15:0] rd, output logic rv, output int waits);
    cpu_req_valid = 1'b1;
    cpu_req_op    = op;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    waits = 0;
    #1;
    while (!cpu_req_ready && waits < 1000) begin
      @(negedge clk); #1;
      waits++;
    end
    @(negedge clk);
    rd = cpu_rsp_rdata;
    rv = cpu_rsp_valid;
    cpu_req_valid = 1'b0;
  endtask

  task automatic obs_read(input logic [7:0] a, output logic [15:0] d);
    obs_rd_en   = 1'b1;
    obs_rd_addr = a;
    @(negedge clk);
    d = obs_rd_data;
    obs_rd_en = 1'b0;
  endtask

  task automatic obs_hold(input logic [7:0] a);
    obs_rd_en   = 1'b1;
    obs_rd_addr = a;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic rv;
    int w;
    cpu_req_valid = 1'b0; cpu_req_op = 2'd0; cpu_req_addr = '0; cpu_req_wdata = '0;
    obs_rd_en = 1'b0; obs_rd_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R9)
    check("R9 busy after reset", 32'(busy), 32'd0);
    check("R9 rsp_valid after reset", 32'(cpu_rsp_valid), 32'd0);

    // vector table: R1 R5 R6 R10
    for (int i = 0; i < 14; i++) begin
      core_op(VEC[i][41:40], VEC[i][39:32], VEC[i][31:16], rd, rv, w);
      if (VEC[i][41:40] == LD) begin
        check($sformatf("R6/R5 vector %0d load data", i), 32'(rd), 32'(VEC[i][15:0]));
        check($sformatf("R10 vector %0d rsp_valid", i), 32'(rv), 32'd1);
      end
      if (VEC[i][41:40] == ST)
        check($sformatf("R1 vector %0d store waits", i), w, 0);
    end

    // observer keeps the port, queue cannot drain
    obs_hold(8'h10);
    core_op(ST, 8'h12, 16'hAAAA, rd, rv, w); check("R1 store 1 waits", w, 0);
    core_op(ST, 8'h12, 16'hBBBB, rd, rv, w); check("R1 store 2 waits", w, 0);
    core_op(ST, 8'h13, 16'hCCCC, rd, rv, w); check("R1 store 3 waits", w, 0);
    core_op(ST, 8'h14, 16'hDDDD, rd, rv, w); check("R1 store 4 waits", w, 0);

    // R2: full queue refuses a store
    cpu_req_valid = 1'b1; cpu_req_op = ST; cpu_req_addr = 8'h15; cpu_req_wdata = 16'hEEEE;
    for (int c = 0; c < 3; c++) begin
      #1; check("R2 store refused when full", 32'(cpu_req_ready), 32'd0);
      @(negedge clk);
    end
    cpu_req_valid = 1'b0;

    // R6: newest of two matching entries
    core_op(LD, 8'h12, 16'h0, rd, rv, w);
    check("R6 forward newest", 32'(rd), 32'h0000_BBBB);
    check("R6 forward without stall", w, 0);

    // R8: load miss refused while observer reads
    cpu_req_valid = 1'b1; cpu_req_op = LD; cpu_req_addr = 8'h10;
    #1; check("R8 load miss stalled by observer", 32'(cpu_req_ready), 32'd0);
    @(negedge clk); #1;
    check("R8 load miss still stalled", 32'(cpu_req_ready), 32'd0);
    @(negedge clk);
    cpu_req_valid = 1'b0;

    // R4: queued stores invisible
    obs_read(8'h12, rd); check("R4 observer sees old 0x12", 32'(rd), 32'h0000_3333);
    obs_read(8'h14, rd); check("R4 observer sees old 0x14", 32'(rd), 32'h0000_6666);

    // R5: load bypasses queued stores, which remain unwritten
    core_op(LD, 8'h11, 16'h0, rd, rv, w);
    check("R5 load miss reads memory", 32'(rd), 32'h0000_5555);
    check("R5 load miss not stalled", w, 0);
    obs_read(8'h12, rd); check("R5 oldest entry still pending", 32'(rd), 32'h0000_3333);

    // R3: same-address order
    core_op(FN, 8'h00, 16'h0, rd, rv, w);
    obs_read(8'h12, rd); check("R3 later store to same address wins", 32'(rd), 32'h0000_BBBB);
    obs_read(8'h14, rd); check("R3 last entry visible after fence", 32'(rd), 32'h0000_DDDD);

    // R3: cross-address visibility order
    core_op(ST, 8'h20, 16'h0001, rd, rv, w);
    core_op(ST, 8'h21, 16'h0002, rd, rv, w);
    core_op(FN, 8'h00, 16'h0, rd, rv, w);
    obs_hold(8'h20);
    core_op(ST, 8'h20, 16'h0A0A, rd, rv, w);
    core_op(ST, 8'h21, 16'h0B0B, rd, rv, w);
    obs_rd_en = 1'b0;
    @(negedge clk);   // one free cycle: only the older entry is written
    obs_read(8'h21, rd); check("R3 younger store not yet visible", 32'(rd), 32'h0000_0002);
    obs_read(8'h20, rd); check("R3 older store visible first", 32'(rd), 32'h0000_0A0A);
    core_op(FN, 8'h00, 16'h0, rd, rv, w);
    obs_read(8'h21, rd); check("R3 younger store after fence", 32'(rd), 32'h0000_0B0B);

    // R7: fence waits exactly for two write-outs
    obs_hold(8'h30);
    core_op(ST, 8'h30, 16'h0001, rd, rv, w);
    core_op(ST, 8'h31, 16'h0002, rd, rv, w);
    obs_rd_en = 1'b0;
    cpu_req_valid = 1'b1; cpu_req_op = FN;
    #1;
    check("R7 busy while fence waits", 32'(busy), 32'd1);
    check("R7 fence refused", 32'(cpu_req_ready), 32'd0);
    @(negedge clk); #1;
    check("R7 busy after first write", 32'(busy), 32'd1);
    @(negedge clk); #1;
    check("R7 busy low after last write", 32'(busy), 32'd0);
    check("R7 fence accepted after last write", 32'(cpu_req_ready), 32'd1);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    obs_read(8'h31, rd); check("R7 stores visible after fence", 32'(rd), 32'h0000_0002);

    // R9: reset drops a queued entry
    obs_hold(8'h30);
    core_op(ST, 8'h30, 16'h9999, rd, rv, w);
    rst_n = 1'b0;
    obs_rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    core_op(FN, 8'h00, 16'h0, rd, rv, w); check("R9 fence accepted after reset", w, 0);
    obs_read(8'h30, rd); check("R9 dropped entry not written", 32'(rd), 32'h0000_0001);
    core_op(LD, 8'h30, 16'h0, rd, rv, w); check("R9 no forwarding from dropped entry", 32'(rd), 32'h0000_0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule